// File: doc/BRIEF.md
# SPI Status Flags and Interrupt Requests

This block keeps the four status flags of a serial peripheral port (transmit empty, receive full, overflow and mode fault) and turns them into two interrupt request lines: one for the transmitter, and one shared by the receiver and the error flags. The shift engine feeds it single-cycle transfer events. A simple register bus feeds it read and write strobes for the status, data and control registers. The block also takes the slave-select level, the master/slave mode bit and the port enable.

Each flag is set by a hardware event and cleared only by a bus access sequence. Receive full and overflow clear when the status register is read while the flag is set and the data register is read later. Mode fault clears when the status register is read while the flag is set and the control register is written later, and only if no fault condition appears during that sequence. The control register holds four enables. When a byte completes while the receive register still holds an unread byte, the new byte is discarded: the block withholds the receive-register load strobe for it.

Top module: `spi_flag_irq`

## Requirements
- R1: After reset, status reads 4'b0001, both interrupt lines are low and all four control enables are zero. Status bit positions: bit 0 transmit empty, bit 1 receive full, bit 2 overflow, bit 3 mode fault.
- R2: A load event sets transmit empty on the next edge, and a data write clears it. When both occur in the same cycle, the data write wins and the flag ends up clear.
- R3: A receive-done event with receive full clear sets receive full, and rx_load is high in that cycle. A data read clears the flag only if a status read has been made while the flag was set, with no data read in between. A data read without such a status read leaves the flag set.
- R4: A receive-done event while receive full is set sets overflow, and rx_load stays low in that cycle. Receive full stays set unless it is cleared in that same cycle.
- R5: Overflow clears on a data read that follows a status read made while overflow was set.
- R6: Mode fault sets when master_mode is 1, ss_n is 0 and the mode-fault enable (control bit 3) is 1.
- R7: Mode fault clears on a control write that follows a status read made while the flag was set. If the fault condition is present at any point from the status read up to and including the write, the flag stays set.
- R8: irq_tx is high exactly when transmit empty is set and the transmit interrupt enable (control bit 0) is 1.
- R9: Receive full drives irq_rxerr only when the receive interrupt enable (control bit 1) and spi_en are both 1.
- R10: Overflow or mode fault drives irq_rxerr only when both the error enable (control bit 2) and the receive interrupt enable (control bit 1) are 1.
- R11: While the mode-fault enable is 0, the mode-fault flag never becomes set, so only overflow can raise the error part of irq_rxerr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| spi_en | input | 1 | Port enable |
| master_mode | input | 1 | 1 when configured as master |
| ss_n | input | 1 | Slave-select level |
| load_evt | input | 1 | Byte moved from transmit buffer to shift register |
| rx_done | input | 1 | Received byte completed in shift register |
| stat_rd | input | 1 | Status register read strobe |
| data_rd | input | 1 | Data register read strobe |
| data_wr | input | 1 | Data register write strobe |
| ctrl_wr | input | 1 | Control register write strobe |
| ctrl_wdata | input | 4 | Control write data: bit0 tx irq en, bit1 rx irq en, bit2 error en, bit3 mode-fault en |
| status | output | 4 | Flag vector: bit0 tx empty, bit1 rx full, bit2 overflow, bit3 mode fault |
| rx_load | output | 1 | Strobe for the receive register to capture the completed byte |
| irq_tx | output | 1 | Transmitter interrupt request |
| irq_rxerr | output | 1 | Receiver/error interrupt request |

## Verification
The hardest situation to reach is a mode-fault clear that fails because the fault condition comes back after the status read has armed the clear. The flag is already set at that point, so no output changes and only the later write shows the outcome. The stimulus sets the fault and releases slave select. It reads status, pulses slave select low for one cycle, and then writes control. It checks that the flag survives this write and that a clean read-then-write sequence afterwards clears it. Each flag and clear sequence is repeated for all sixteen control values with the port enable both on and off. After every cycle, the bench compares the interrupt lines with values computed from its own flag model.

// File: rtl/spi_flag_irq.sv
module spi_flag_irq (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       spi_en,
  input  logic       master_mode,
  input  logic       ss_n,
  input  logic       load_evt,
  input  logic       rx_done,
  input  logic       stat_rd,
  input  logic       data_rd,
  input  logic       data_wr,
  input  logic       ctrl_wr,
  input  logic [3:0] ctrl_wdata,
  output logic [3:0] status,
  output logic       rx_load,
  output logic       irq_tx,
  output logic       irq_rxerr
);
  localparam int TXIE = 0;
  localparam int RXIE = 1;
  localparam int ERIE = 2;
  localparam int MFEN = 3;

  logic [3:0] ctl_q;
  logic tx_empty, rx_full, ovf, modf;
  logic rx_arm, ovf_arm, modf_arm;
  logic fault_now;

  assign fault_now = master_mode & ~ss_n & ctl_q[MFEN];
  assign rx_load   = rx_done & ~rx_full;
  assign status    = {modf, ovf, rx_full, tx_empty};

  assign irq_tx    = tx_empty & ctl_q[TXIE];
  assign irq_rxerr = (rx_full & ctl_q[RXIE] & spi_en)
                   | ((ovf | modf) & ctl_q[ERIE] & ctl_q[RXIE]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q    <= '0;
      tx_empty <= 1'b1;
      rx_full  <= 1'b0;
      ovf      <= 1'b0;
      modf     <= 1'b0;
      rx_arm   <= 1'b0;
      ovf_arm  <= 1'b0;
      modf_arm <= 1'b0;
    end else begin
      if (ctrl_wr) ctl_q <= ctrl_wdata;

      if (data_wr)       tx_empty <= 1'b0;
      else if (load_evt) tx_empty <= 1'b1;

      rx_full <= (rx_done & ~rx_full) | (rx_full & ~(data_rd & rx_arm));
      ovf     <= (rx_done & rx_full) | (ovf & ~(data_rd & ovf_arm));
      modf    <= fault_now | (modf & ~(ctrl_wr & modf_arm));

      if (data_rd)                rx_arm <= 1'b0;
      else if (stat_rd & rx_full) rx_arm <= 1'b1;

      if (data_rd)            ovf_arm <= 1'b0;
      else if (stat_rd & ovf) ovf_arm <= 1'b1;

      if (fault_now | ctrl_wr) modf_arm <= 1'b0;
      else if (stat_rd & modf) modf_arm <= 1'b1;
    end
  end
endmodule

module spi_flag_irq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       load_evt,
  input logic       data_wr,
  input logic       rx_done,
  input logic [3:0] status,
  input logic       rx_load,
  input logic [3:0] ctl,
  input logic       irq_tx,
  input logic       irq_rxerr
);
  AST_TX_SET: assert property (@(posedge clk) disable iff (!rst_n) (load_evt && !data_wr) |=> status[0]); // R2
  AST_TX_CLR: assert property (@(posedge clk) disable iff (!rst_n) data_wr |=> !status[0]); // R2
  AST_RX_KEEP: assert property (@(posedge clk) disable iff (!rst_n) (rx_done && status[1]) |-> !rx_load); // R4
  AST_OVF_SET: assert property (@(posedge clk) disable iff (!rst_n) (rx_done && status[1]) |=> status[2]); // R4
  AST_MODF_MASK: assert property (@(posedge clk) disable iff (!rst_n) (!ctl[3] && !status[3]) |=> !status[3]); // R11
  AST_IRQ_TX: assert property (@(posedge clk) disable iff (!rst_n) irq_tx |-> (status[0] && ctl[0])); // R8
  AST_IRQ_RXERR: assert property (@(posedge clk) disable iff (!rst_n) irq_rxerr |-> (ctl[1] && (status[3:1] != 3'b000))); // R10
endmodule

bind spi_flag_irq spi_flag_irq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .load_evt(load_evt), .data_wr(data_wr),
  .rx_done(rx_done), .status(status), .rx_load(rx_load), .ctl(ctl_q),
  .irq_tx(irq_tx), .irq_rxerr(irq_rxerr)
);

// File: tb/tb_spi_flag_irq.sv
`timescale 1ns/1ps
module tb_spi_flag_irq;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0, spi_en = 1'b0, master_mode = 1'b0, ss_n = 1'b1;
  logic load_evt = 0, rx_done = 0, stat_rd = 0, data_rd = 0, data_wr = 0, ctrl_wr = 0;
  logic [3:0] ctrl_wdata = '0;
  logic [3:0] status;
  logic rx_load, irq_tx, irq_rxerr;

  spi_flag_irq dut (.*);

  int checks = 0, fails = 0;
  bit done = 0;

  logic m_tx, m_rx, m_ovf, m_modf, a_rx, a_ovf, a_modf;
  logic [3:0] m_ctl;

  localparam logic [5:0] LD = 6'h01, RXD = 6'h02, SRD = 6'h04, DRD = 6'h08, DWR = 6'h10, CWR = 6'h20;

  task automatic chk(input string tag, input string what, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic chk_outs(input string tag);
    logic e_tx, e_rx;
    e_tx = m_tx & m_ctl[0];
    e_rx = (m_rx & m_ctl[1] & spi_en) | ((m_ovf | m_modf) & m_ctl[2] & m_ctl[1]);
    chk(tag, "status", status, {m_modf, m_ovf, m_rx, m_tx});
    chk(tag, "irq_tx(R8)", {3'b0, irq_tx}, {3'b0, e_tx});
    chk(tag, "irq_rxerr(R9/R10)", {3'b0, irq_rxerr}, {3'b0, e_rx});
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    @(negedge clk); @(negedge clk); rst_n = 1;
    m_tx = 1; m_rx = 0; m_ovf = 0; m_modf = 0; a_rx = 0; a_ovf = 0; a_modf = 0; m_ctl = 0;
    chk_outs("R1");
  endtask

  task automatic step(input logic [5:0] ev, input logic [3:0] wd, input string tag);
    logic f, n_tx, n_rx, n_ovf, n_modf;
    @(negedge clk);
    {ctrl_wr, data_wr, data_rd, stat_rd, rx_done, load_evt} = ev;
    ctrl_wdata = wd;
    #1;
    chk(tag, "rx_load(R3/R4)", {3'b0, rx_load}, {3'b0, ev[1] & ~m_rx});
    f = master_mode & ~ss_n & m_ctl[3];
    n_tx = m_tx;
    if (ev[0]) n_tx = 1;
    if (ev[4]) n_tx = 0;
    n_rx = m_rx; n_ovf = m_ovf; n_modf = m_modf;
    if (ev[3] && a_rx) n_rx = 0;
    if (ev[3] && a_ovf) n_ovf = 0;
    if (ev[1] && !m_rx) n_rx = 1;
    if (ev[1] && m_rx) n_ovf = 1;
    if (ev[5] && a_modf) n_modf = 0;
    if (f) n_modf = 1;
    if (ev[3]) begin a_rx = 0; a_ovf = 0; end
    else begin
      if (ev[2] && m_rx) a_rx = 1;
      if (ev[2] && m_ovf) a_ovf = 1;
    end
    if (f || ev[5]) a_modf = 0;
    else if (ev[2] && m_modf) a_modf = 1;
    if (ev[5]) m_ctl = wd;
    m_tx = n_tx; m_rx = n_rx; m_ovf = n_ovf; m_modf = n_modf;
    @(negedge clk);
    {ctrl_wr, data_wr, data_rd, stat_rd, rx_done, load_evt} = '0;
    chk_outs(tag);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    for (int en = 0; en < 2; en++) begin
      for (int cfg = 0; cfg < 16; cfg++) begin
        do_reset();
        spi_en = en[0];
        step(CWR, cfg[3:0], "R8");
        step(DWR, 0, "R2");
        step(LD, 0, "R2");
        step(LD | DWR, 0, "R2");
        step(LD, 0, "R2");
        step(RXD, 0, "R3");
        step(DRD, 0, "R3");
        step(RXD, 0, "R4 R10");
        step(SRD, 0, "R5");
        step(DRD, 0, "R5");
        step(RXD, 0, "R9");
        step(SRD, 0, "R3");
        step(DRD, 0, "R3");
        master_mode = 1; ss_n = 0;
        step(0, 0, "R6 R11");
        ss_n = 1;
        step(SRD, 0, "R7");
        ss_n = 0;
        step(0, 0, "R7");
        ss_n = 1;
        step(CWR, cfg[3:0], "R7");
        step(SRD, 0, "R7");
        ss_n = 0;
        step(CWR, cfg[3:0], "R7");
        ss_n = 1;
        step(SRD, 0, "R7");
        step(0, 0, "R7");
        step(CWR, cfg[3:0], "R7 R10");
        master_mode = 0;
        step(CWR, 4'h0, "R11");
        master_mode = 1; ss_n = 0;
        step(0, 0, "R11");
        master_mode = 0; ss_n = 1;
      end
    end
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule